// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block sits on the host side of a three-wire serial EEPROM made of 16-bit words. It takes one command at a time through a valid/ready handshake and turns it into a serial frame on chip select, serial clock and data-in. A read command can cover several consecutive words. The block keeps the serial clock running from one word to the next, so only one command header goes out. Read words come back on a data output, one single-cycle strobe per word.

After a write, erase, write-all or erase-all frame, the controller releases chip select so the target starts programming. After the minimum deselect time it selects the target again, holds data-in low and watches the target's data-out. A low level means the target is still busy; a high level means programming is done. This lets the next command go out as soon as the target is ready rather than after the worst-case 10 ms. A poll window, set by a parameter, limits the wait. When the window runs out, the controller sets a sticky error flag and gives up on that operation.

Top module: `mw_eeprom_host`

## Requirements
- R1: A frame is a 1 start bit, then two opcode bits, then eight address bits MSB first. The wire opcodes are: read 10, write 01, erase 11, write-all 00 with address 01xxxxxx, erase-all 00 with address 10xxxxxx. Data-in changes only while the serial clock is low. Each clock half-period lasts CLK_DIV cycles.
- R2: For write and write-all, the 16-bit data word follows the address on data-in, MSB first.
- R3: For a read, the controller ignores the first data-out bit after the address (the dummy 0). It then assembles 16 bits MSB first and presents them on rd_data with a one-cycle rd_valid pulse, while chip select is still high.
- R4: A read returns cmd_count consecutive words (a count of 0 reads one word) from one header, with no break in the serial clock between words.
- R5: After a programming frame, the controller waits out the deselect time, then raises chip select with data-in and the serial clock low. It stays in this poll until data-out reads high, and does not wait for the poll window to elapse.
- R6: Every chip-select low interval lasts at least CS_LOW_MIN clock cycles.
- R7: cmd_ready is high only when the controller is idle: chip select is low and no programming poll is in progress. A command is accepted when cmd_valid and cmd_ready are both high. Opcodes 0 read, 1 write, 2 erase, 3 write-all and 4 erase-all are valid. Codes 5 to 7 are accepted and discarded without a frame.
- R8: If data-out stays low for POLL_TIMEOUT cycles of polling, timeout_err rises, chip select drops and the controller returns to idle without polling again.
- R9: timeout_err stays set until the next command is accepted, and clears on that acceptance.
- R10: During reset, chip select, serial clock, rd_valid and timeout_err are low, and cmd_ready is high once reset is released.
- R11: The serial clock is low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| cmd_op | input | 3 | Operation: 0 read, 1 write, 2 erase, 3 write-all, 4 erase-all |
| cmd_addr | input | AW (8) | Word address |
| cmd_wdata | input | DW (16) | Word to program for write and write-all |
| cmd_count | input | LW (8) | Words to read, 0 meaning one |
| rd_valid | output | 1 | One-cycle strobe for each word read |
| rd_data | output | DW (16) | Word read |
| timeout_err | output | 1 | Sticky flag: the programming poll expired |
| ee_cs | output | 1 | Target chip select, active high |
| ee_sk | output | 1 | Target serial clock |
| ee_di | output | 1 | Serial data to the target |
| ee_do | input | 1 | Serial data from the target |

## Verification
The bench drives a behavioural target that has busy timing and a stuck-busy mode. It checks the following corner cases:
- **Dummy bit.** A controller that does not skip the dummy bit returns every word shifted right by one.
- **Burst read.** A burst read that crosses the top address checks that the clock keeps running: a controller that restarts the clock or reissues the header loses or repeats words.
- **Poll exit.** The poll is timed from both sides. A controller that waits the full window finishes too late. One that ignores the stuck target never sets the error flag. One that polls with data-in high or the clock toggling would start a new frame.
- **Discarded opcodes and the sticky flag.** An unused opcode must leave chip select untouched. The error flag is checked across an idle period, where it must stay set, and at the next accepted command, where it must clear.

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host #(
  parameter int CLK_DIV      = 4,
  parameter int CS_LOW_MIN   = 8,
  parameter int POLL_TIMEOUT = 3_000_000,
  parameter int AW           = 8,
  parameter int DW           = 16,
  parameter int LW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [LW-1:0] cmd_count,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          timeout_err,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di,
  input  logic          ee_do
);
  localparam int HB  = 3 + AW;
  localparam int FW  = HB + DW;
  localparam int SW  = $clog2(HB + 1 + DW * (1 << LW) + 1);
  localparam int DVW = $clog2(CLK_DIV + 1);
  localparam int GW  = $clog2(CS_LOW_MIN + 1);
  localparam int PW  = $clog2(POLL_TIMEOUT + 1);
  localparam int BW  = $clog2(DW);

  localparam logic [1:0] S_IDLE = 2'd0, S_SHIFT = 2'd1, S_GAP = 2'd2, S_POLL = 2'd3;

  logic [1:0]    st;
  logic          go_poll, cs_q, sk_q, is_read, rd_v, err_q;
  logic [FW-1:0] sreg;
  logic [SW-1:0] slot, slot_last;
  logic [DVW-1:0] div;
  logic [DW-1:0] rx, rd_q;
  logic [BW-1:0] rbit;
  logic [GW-1:0] gcnt;
  logic [PW-1:0] pcnt;

  logic [HB-1:0] hdr;
  logic [SW-1:0] last_c, nwords;
  logic          valid_op, has_data;

  always_comb begin
    nwords   = (cmd_count == '0) ? SW'(1) : SW'(cmd_count);
    valid_op = 1'b1;
    has_data = 1'b0;
    hdr      = '0;
    last_c   = SW'(HB - 1);
    case (cmd_op)
      3'd0: begin hdr = {3'b110, cmd_addr}; last_c = SW'(HB) + SW'(DW) * nwords; end
      3'd1: begin hdr = {3'b101, cmd_addr}; last_c = SW'(FW - 1); has_data = 1'b1; end
      3'd2: hdr = {3'b111, cmd_addr};
      3'd3: begin hdr = {3'b100, 2'b01, {(AW-2){1'b0}}}; last_c = SW'(FW - 1); has_data = 1'b1; end
      3'd4: hdr = {3'b100, 2'b10, {(AW-2){1'b0}}};
      default: valid_op = 1'b0;
    endcase
  end

  assign cmd_ready   = (st == S_IDLE);
  assign rd_valid    = rd_v;
  assign rd_data     = rd_q;
  assign timeout_err = err_q;
  assign ee_cs       = cs_q;
  assign ee_sk       = sk_q;
  assign ee_di       = cs_q && (st == S_SHIFT) && sreg[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; go_poll <= 1'b0; cs_q <= 1'b0; sk_q <= 1'b0; is_read <= 1'b0;
      rd_v <= 1'b0; err_q <= 1'b0; sreg <= '0; slot <= '0; slot_last <= '0;
      div <= '0; rx <= '0; rd_q <= '0; rbit <= '0; gcnt <= '0; pcnt <= '0;
    end else begin
      rd_v <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          err_q <= 1'b0;
          if (valid_op) begin
            st        <= S_SHIFT;
            cs_q      <= 1'b1;
            sk_q      <= 1'b0;
            sreg      <= {hdr, has_data ? cmd_wdata : {DW{1'b0}}};
            slot      <= '0;
            slot_last <= last_c;
            is_read   <= (cmd_op == 3'd0);
            div       <= '0;
            rbit      <= '0;
          end
        end
        S_SHIFT: begin
          if (div == DVW'(CLK_DIV - 1)) begin
            div <= '0;
            if (!sk_q) begin
              sk_q <= 1'b1;
              if (is_read && slot > SW'(HB)) begin
                rx <= {rx[DW-2:0], ee_do};
                if (rbit == BW'(DW - 1)) begin
                  rbit <= '0;
                  rd_v <= 1'b1;
                  rd_q <= {rx[DW-2:0], ee_do};
                end else begin
                  rbit <= rbit + 1'b1;
                end
              end
            end else begin
              sk_q <= 1'b0;
              if (slot == slot_last) begin
                cs_q    <= 1'b0;
                st      <= S_GAP;
                gcnt    <= '0;
                go_poll <= !is_read;
              end else begin
                slot <= slot + 1'b1;
                sreg <= {sreg[FW-2:0], 1'b0};
              end
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        S_GAP: begin
          if (gcnt == GW'(CS_LOW_MIN - 1)) begin
            if (go_poll) begin
              st   <= S_POLL;
              cs_q <= 1'b1;
              pcnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt != '0 && ee_do) begin
            cs_q <= 1'b0; st <= S_GAP; gcnt <= '0; go_poll <= 1'b0;
          end else if (pcnt == PW'(POLL_TIMEOUT - 1)) begin
            err_q <= 1'b1; cs_q <= 1'b0; st <= S_GAP; gcnt <= '0; go_poll <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
  parameter int CS_LOW_MIN = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       rd_valid,
  input logic       timeout_err,
  input logic       ee_cs,
  input logic       ee_sk,
  input logic       ee_di,
  input logic [1:0] st
);
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   low_cnt <= CS_LOW_MIN;
    else if (ee_cs)               low_cnt <= 0;
    else if (low_cnt < CS_LOW_MIN) low_cnt <= low_cnt + 1;
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) !ee_cs |-> !ee_sk); // R11
  AST_DI_HELD_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R1
  AST_RD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> ee_cs); // R3
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready |-> (!ee_cs && !ee_sk)); // R7
  AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd3) |-> (ee_cs && !ee_di && !ee_sk)); // R5
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_cs) |-> (low_cnt >= CS_LOW_MIN)); // R6
  AST_ERR_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout_err) |-> ($past(st) == 2'd3 && !ee_cs)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (timeout_err && !(cmd_ready && $past(cmd_ready))) |=> timeout_err); // R9
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.CS_LOW_MIN(CS_LOW_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rd_valid(rd_valid),
  .timeout_err(timeout_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .st(st)
);

// File: tb/mw_eeprom_host_tb.sv
module mw_eeprom_host_tb_top;
  localparam int CLK_DIV = 3, CS_LOW_MIN = 6, POLL_TIMEOUT = 3000, BUSY = 400;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0, cmd_count = '0;
  logic [15:0] cmd_wdata = '0, rd_data;
  logic rd_valid, timeout_err, ee_cs, ee_sk, ee_di, ee_do;

  mw_eeprom_host #(.CLK_DIV(CLK_DIV), .CS_LOW_MIN(CS_LOW_MIN), .POLL_TIMEOUT(POLL_TIMEOUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_count(cmd_count), .rd_valid(rd_valid),
    .rd_data(rd_data), .timeout_err(timeout_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do));

  function automatic logic [15:0] seed(input int i);
    return 16'(i * 257) ^ 16'h5A00;
  endfunction

  // behavioural serial target
  logic [15:0] t_mem [256];
  bit t_init = 0, t_stuck = 0, t_started = 0, t_rd = 0;
  int t_busy = 0, t_nb = 0, t_wn = 0, t_rbit = 0;
  logic [9:0] t_hdr = '0, t_last_hdr = '0;
  logic [15:0] t_word = '0, t_wdat = '0, t_last_wdat = '0;
  logic [7:0] t_addr = '0;
  logic t_dobit = 1'b0, sk_p = 1'b0, cs_p = 1'b0;

  assign ee_do = (ee_cs && t_busy > 0) ? 1'b0 : (t_rd ? t_dobit : 1'b1);

  always @(negedge clk) begin
    logic [9:0] nh;
    logic [7:0] na;
    if (!t_init) begin
      for (int i = 0; i < 256; i++) t_mem[i] <= seed(i);
      t_init <= 1'b1;
    end
    sk_p <= ee_sk;
    cs_p <= ee_cs;
    if (t_busy > 0 && !t_stuck) t_busy <= t_busy - 1;
    if (ee_cs && ee_sk && !sk_p) begin
      if (!t_started) begin
        if (ee_di) begin t_started <= 1'b1; t_nb <= 0; t_wn <= 0; end
      end else if (t_nb < 10) begin
        nh = {t_hdr[8:0], ee_di};
        t_hdr <= nh;
        t_nb <= t_nb + 1;
        if (t_nb == 9) begin
          t_last_hdr <= nh;
          if (nh[9:8] == 2'b10) begin
            t_rd <= 1'b1; t_dobit <= 1'b0; t_addr <= nh[7:0]; t_word <= t_mem[nh[7:0]]; t_rbit <= 15;
          end
        end
      end else if (t_rd) begin
        t_dobit <= t_word[t_rbit];
        if (t_rbit == 0) begin
          na = t_addr + 8'd1;
          t_addr <= na; t_word <= t_mem[na]; t_rbit <= 15;
        end else t_rbit <= t_rbit - 1;
      end else begin
        t_wdat <= {t_wdat[14:0], ee_di};
        t_wn <= t_wn + 1;
      end
    end
    if (!ee_cs && cs_p) begin
      if (t_started && t_nb == 10 && !t_rd) begin
        t_last_wdat <= t_wdat;
        case (t_hdr[9:8])
          2'b01: if (t_wn == 16) begin t_mem[t_hdr[7:0]] <= t_wdat; t_busy <= BUSY; end
          2'b11: begin t_mem[t_hdr[7:0]] <= 16'hFFFF; t_busy <= BUSY; end
          2'b00: begin
            if (t_hdr[7:6] == 2'b01 && t_wn == 16) begin
              for (int i = 0; i < 256; i++) t_mem[i] <= t_wdat;
              t_busy <= BUSY;
            end else if (t_hdr[7:6] == 2'b10) begin
              for (int i = 0; i < 256; i++) t_mem[i] <= 16'hFFFF;
              t_busy <= BUSY;
            end
          end
          default: ;
        endcase
      end
      t_started <= 1'b0;
      t_rd <= 1'b0;
    end
  end

  // reference model state owned by the stimulus process
  logic [15:0] e_mem [256];
  logic [15:0] exp_w [64];
  int exp_n = 0;
  int n_tests = 0, n_fail = 0;

  // per-clock comparison owned by the monitor
  int mon_tests = 0, mon_fail = 0, n_rd = 0, cyc = 0, m_rise = -1, m_low = CS_LOW_MIN, m_rises = 0;
  logic m_sk = 1'b0, m_di = 1'b0, m_cs = 1'b0;

  task automatic mchk(input bit ok, input string req, input string what, input longint act, input longint exp);
    mon_tests++;
    if (!ok) begin
      mon_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (rd_valid) begin
        if (n_rd < exp_n) mchk(rd_data == exp_w[n_rd], "R3", "read word", rd_data, exp_w[n_rd]);
        else mchk(1'b0, "R3", "unexpected read strobe", n_rd, exp_n);
        n_rd++;
      end
      if (!ee_cs) mchk(!ee_sk, "R11", "clock while deselected", ee_sk, 0);
      if (ee_sk && !m_sk) begin
        if (ee_cs && m_rise >= 0) mchk(cyc - m_rise == 2 * CLK_DIV, "R1", "clock period", cyc - m_rise, 2 * CLK_DIV);
        m_rise = cyc;
      end
      if (!ee_cs) m_rise = -1;
      if (ee_sk && m_sk) mchk(ee_di == m_di, "R1", "data-in moved while clock high", ee_di, m_di);
      if (ee_cs && !m_cs) begin
        mchk(m_low >= CS_LOW_MIN, "R6", "deselect time", m_low, CS_LOW_MIN);
        m_rises++;
      end
      m_low = ee_cs ? 0 : m_low + 1;
      if (ee_cs && t_busy > 0 && !t_started) mchk(!ee_di && !ee_sk, "R5", "poll lines", {ee_di, ee_sk}, 0);
      if (cmd_ready) mchk(!ee_cs && (t_busy == 0 || timeout_err), "R7", "ready while busy", {ee_cs, 1'b1}, 0);
      m_sk = ee_sk; m_di = ee_di; m_cs = ee_cs;
      if (cyc > 150000) begin
        mon_fail++; mon_tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests + mon_tests, n_fail + mon_fail);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d, input logic [7:0] n);
    int nw;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_count = n; cmd_valid = 1'b1;
    case (op)
      3'd0: begin
        nw = (n == 0) ? 1 : int'(n);
        for (int i = 0; i < nw; i++) begin exp_w[exp_n] = e_mem[8'(int'(a) + i)]; exp_n++; end
      end
      3'd1: e_mem[a] = d;
      3'd2: e_mem[a] = 16'hFFFF;
      3'd3: for (int i = 0; i < 256; i++) e_mem[i] = d;
      3'd4: for (int i = 0; i < 256; i++) e_mem[i] = 16'hFFFF;
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  initial begin
    int t0, base, rises;
    for (int i = 0; i < 256; i++) e_mem[i] = seed(i);
    repeat (5) @(negedge clk);
    chk(!ee_cs && !ee_sk, "R10", "lines in reset", {ee_cs, ee_sk}, 0);
    chk(!rd_valid && !timeout_err, "R10", "flags in reset", {rd_valid, timeout_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready, "R10", "ready after reset", cmd_ready, 1);

    issue(3'd1, 8'h05, 16'hA5C3, 8'd0);
    t0 = cyc;
    repeat (4) @(negedge clk);
    chk(!cmd_ready, "R7", "ready during frame", cmd_ready, 0);
    wait_ready();
    chk(cyc - t0 > BUSY && cyc - t0 < POLL_TIMEOUT, "R5", "write to ready cycles", cyc - t0, BUSY);
    chk(t_last_hdr == {2'b01, 8'h05}, "R1", "write header", t_last_hdr, {2'b01, 8'h05});
    chk(t_last_wdat == 16'hA5C3, "R2", "write data", t_last_wdat, 16'hA5C3);
    chk(!timeout_err, "R8", "no error on normal poll", timeout_err, 0);

    issue(3'd0, 8'h05, 16'h0, 8'd1);
    wait_ready();
    chk(n_rd == exp_n, "R3", "single read count", n_rd, exp_n);
    chk(t_last_hdr == {2'b10, 8'h05}, "R1", "read header", t_last_hdr, {2'b10, 8'h05});

    issue(3'd1, 8'hFE, 16'h1357, 8'd0);
    issue(3'd1, 8'hFF, 16'h2468, 8'd0);
    issue(3'd1, 8'h00, 16'hBEEF, 8'd0);
    base = n_rd;
    issue(3'd0, 8'hFE, 16'h0, 8'd3);
    wait_ready();
    chk(n_rd - base == 3, "R4", "burst across top address", n_rd - base, 3);

    base = n_rd;
    issue(3'd0, 8'h07, 16'h0, 8'd0);
    wait_ready();
    chk(n_rd - base == 1, "R4", "count zero reads one word", n_rd - base, 1);

    issue(3'd2, 8'h20, 16'h0, 8'd0);
    wait_ready();
    chk(t_last_hdr == {2'b11, 8'h20}, "R1", "erase header", t_last_hdr, {2'b11, 8'h20});
    issue(3'd0, 8'h20, 16'h0, 8'd1);

    issue(3'd3, 8'h00, 16'h3C96, 8'd0);
    wait_ready();
    chk(t_last_hdr[9:6] == 4'b0001, "R1", "write-all header", t_last_hdr, 10'h040);
    chk(t_last_wdat == 16'h3C96, "R2", "write-all data", t_last_wdat, 16'h3C96);
    base = n_rd;
    issue(3'd0, 8'h80, 16'h0, 8'd4);
    wait_ready();
    chk(n_rd - base == 4, "R4", "burst of four", n_rd - base, 4);

    issue(3'd4, 8'h00, 16'h0, 8'd0);
    wait_ready();
    chk(t_last_hdr[9:6] == 4'b0010, "R1", "erase-all header", t_last_hdr, 10'h080);
    issue(3'd0, 8'h10, 16'h0, 8'd2);
    wait_ready();
    chk(n_rd == exp_n, "R3", "all reads returned", n_rd, exp_n);

    rises = m_rises;
    issue(3'd5, 8'h00, 16'h0, 8'd0);
    repeat (40) @(negedge clk);
    chk(m_rises == rises && cmd_ready, "R7", "unused opcode discarded", m_rises - rises, 0);

    t_stuck = 1;
    issue(3'd1, 8'h33, 16'h1111, 8'd0);
    t0 = cyc;
    wait_ready();
    chk(timeout_err, "R8", "error after stuck target", timeout_err, 1);
    chk(cyc - t0 >= POLL_TIMEOUT, "R8", "poll window length", cyc - t0, POLL_TIMEOUT);
    chk(!ee_cs, "R8", "select released", ee_cs, 0);
    rises = m_rises;
    repeat (200) @(negedge clk);
    chk(m_rises == rises, "R8", "no retry after timeout", m_rises - rises, 0);
    chk(timeout_err, "R9", "error held while idle", timeout_err, 1);
    t_stuck = 0;
    while (t_busy != 0) @(negedge clk);
    issue(3'd0, 8'h33, 16'h0, 8'd1);
    chk(!timeout_err, "R9", "error cleared on accept", timeout_err, 0);
    wait_ready();
    chk(n_rd == exp_n, "R3", "read after timeout", n_rd, exp_n);

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests + mon_tests, n_fail + mon_fail);
    $finish;
  end
endmodule